// File: doc/BRIEF.md
# Quadrant-Folding Sine/Cosine Lookup

This block turns an unsigned phase angle into its sine and its cosine over the full circle. It reads them from a table that holds only the first quarter of the circle. Each table angle has two entries: the sine at an even address and the cosine at the next odd address. The two addresses sit in two separate banks. The sine is read from the even bank in one cycle, and the cosine is read from the odd bank in the following cycle. Because each sample uses each bank only once, a new phase can be accepted on every clock.

The two most significant phase bits select the quadrant. The quadrant decides two things: which of the two stored values drives each output, and whether that value is negated. The table is filled at elaboration from a computed function, so no data file is needed. Results leave the block in the order the phases arrived, with a fixed latency.

Top module: `quad_trig_lut`

## Requirements
- R1: While reset is held, and until the first result, `out_valid` is 0 and `out_sin` and `out_cos` are both 0.
- R2: Phase bits [PHASE_W-1:PHASE_W-2] give the quadrant and the lower IDX_W = PHASE_W-2 bits give the index k. For quadrant 0, out_sin = s and out_cos = c, where s = round(M*sin(k*pi/2^(IDX_W+1))), c is the same with cosine, and M = 2^(AMP_W-1)-1. Table entry 2k holds s and entry 2k+1 holds c.
- R3: A phase accepted with `in_valid` high on clock edge e produces `out_valid` high after edge e+2. Back-to-back inputs produce back-to-back results, in input order.
- R4: The magnitude of both outputs never exceeds M. Phase 0 gives sine 0 and cosine M.
- R5: Quadrant 1 gives out_sin = c and out_cos = -s.
- R6: Quadrant 2 gives out_sin = -s and out_cos = -c.
- R7: Quadrant 3 gives out_sin = -c and out_cos = s.
- R8: In a cycle with `out_valid` low, `out_sin` and `out_cos` hold the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Phase strobe |
| in_phase | input | PHASE_W | Unsigned phase; the top two bits are the quadrant |
| out_valid | output | 1 | Result strobe |
| out_sin | output | AMP_W | Signed sine |
| out_cos | output | AMP_W | Signed cosine |

## Verification
The bench builds the block with PHASE_W = 8 and AMP_W = 12. At that size the table holds 64 angles per bank, so every one of the 256 phases can be swept back to back, and each quadrant fold is checked at every index. This includes the edges of each quadrant, such as 0, 63, 64, 191 and 255. Gapped and isolated strobes show that the fixed latency, the input order and the output hold (R8) all survive idle cycles between phases.

// File: rtl/trig_pkg.sv
package trig_pkg;

  localparam real HALF_PI = 3.141592653589793 / 2.0;

  // Value for logical table entry addr: even entries hold sine and odd entries
  // hold cosine, both for index addr/2 of the first quadrant.
  function automatic int lut_entry(input int addr, input int idx_w, input int amp_w);
    real ang;
    real v;
    int  mag;
    mag = (1 << (amp_w - 1)) - 1;
    ang = real'(addr >> 1) * HALF_PI / real'(1 << idx_w);
    v   = (addr % 2 == 1) ? $cos(ang) : $sin(ang);
    return $rtoi(v * real'(mag) + 0.5);
  endfunction

  // Quadrant fold for the sine output.
  function automatic logic signed [31:0] fold_sin(input logic [1:0] q,
                                                  input logic signed [31:0] s,
                                                  input logic signed [31:0] c);
    case (q)
      2'd0:    return s;
      2'd1:    return c;
      2'd2:    return -s;
      default: return -c;
    endcase
  endfunction

  // Quadrant fold for the cosine output.
  function automatic logic signed [31:0] fold_cos(input logic [1:0] q,
                                                  input logic signed [31:0] s,
                                                  input logic signed [31:0] c);
    case (q)
      2'd0:    return c;
      2'd1:    return -s;
      2'd2:    return -c;
      default: return s;
    endcase
  endfunction

endpackage

// File: rtl/trig_bank.sv
module trig_bank #(
  parameter int IDX_W  = 8,
  parameter int AMP_W  = 16,
  parameter int PARITY = 0
) (
  input  logic                    clk,
  input  logic                    rd_en,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic signed [AMP_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic signed [AMP_W-1:0] mem [DEPTH];

  initial begin
    for (int k = 0; k < DEPTH; k++)
      mem[k] = AMP_W'(trig_pkg::lut_entry(2 * k + PARITY, IDX_W, AMP_W));
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/trig_fold.sv
module trig_fold #(
  parameter int AMP_W = 16
) (
  input  logic [1:0]              quad,
  input  logic signed [AMP_W-1:0] s_in,
  input  logic signed [AMP_W-1:0] c_in,
  output logic signed [AMP_W-1:0] sin_o,
  output logic signed [AMP_W-1:0] cos_o
);
  logic signed [31:0] s_w, c_w, sin_w, cos_w;

  always_comb begin
    s_w   = 32'(s_in);
    c_w   = 32'(c_in);
    sin_w = trig_pkg::fold_sin(quad, s_w, c_w);
    cos_w = trig_pkg::fold_cos(quad, s_w, c_w);
    sin_o = sin_w[AMP_W-1:0];
    cos_o = cos_w[AMP_W-1:0];
  end
endmodule

// File: rtl/quad_trig_lut.sv
module quad_trig_lut #(
  parameter int PHASE_W = 10,
  parameter int AMP_W   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [PHASE_W-1:0]      in_phase,
  output logic                    out_valid,
  output logic signed [AMP_W-1:0] out_sin,
  output logic signed [AMP_W-1:0] out_cos
);
  localparam int IDX_W = PHASE_W - 2;

  // stage 1: even (sine) bank read
  logic             s1_valid;
  logic [1:0]       s1_quad;
  logic [IDX_W-1:0] s1_idx;
  logic signed [AMP_W-1:0] even_q;

  // stage 2: odd (cosine) bank read
  logic             s2_valid;
  logic [1:0]       s2_quad;
  logic signed [AMP_W-1:0] s2_sin;
  logic signed [AMP_W-1:0] s2_cos;

  logic signed [AMP_W-1:0] fold_sin_w, fold_cos_w;

  trig_bank #(.IDX_W(IDX_W), .AMP_W(AMP_W), .PARITY(0)) u_even (
    .clk(clk), .rd_en(in_valid), .rd_idx(in_phase[IDX_W-1:0]), .rd_data(even_q));

  trig_bank #(.IDX_W(IDX_W), .AMP_W(AMP_W), .PARITY(1)) u_odd (
    .clk(clk), .rd_en(s1_valid), .rd_idx(s1_idx), .rd_data(s2_cos));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_quad  <= '0;
      s1_idx   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_quad <= in_phase[PHASE_W-1 -: 2];
        s1_idx  <= in_phase[IDX_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_quad  <= '0;
      s2_sin   <= '0;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) begin
        s2_quad <= s1_quad;
        s2_sin  <= even_q;
      end
    end
  end

  trig_fold #(.AMP_W(AMP_W)) u_fold (
    .quad(s2_quad), .s_in(s2_sin), .c_in(s2_cos),
    .sin_o(fold_sin_w), .cos_o(fold_cos_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sin   <= '0;
      out_cos   <= '0;
    end else begin
      out_valid <= s2_valid;
      if (s2_valid) begin
        out_sin <= fold_sin_w;
        out_cos <= fold_cos_w;
      end
    end
  end
endmodule

// File: rtl/trig_chk.sv
module trig_chk #(
  parameter int AMP_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic signed [AMP_W-1:0] out_sin,
  input logic signed [AMP_W-1:0] out_cos,
  input logic                    s2_valid,
  input logic [1:0]              s2_quad,
  input logic signed [AMP_W-1:0] s2_sin,
  input logic signed [AMP_W-1:0] s2_cos
);
  localparam logic signed [AMP_W-1:0] MINV = {1'b1, {(AMP_W-1){1'b0}}};

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R3
  AST_MAG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sin != MINV && out_cos != MINV)); // R4
  AST_FOLD_Q0: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && s2_quad == 2'd0) |=> (out_sin == $past(s2_sin) && out_cos == $past(s2_cos))); // R2
  AST_FOLD_Q1: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && s2_quad == 2'd1) |=> (out_sin == $past(s2_cos) && out_cos == -$past(s2_sin))); // R5
  AST_FOLD_Q2: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && s2_quad == 2'd2) |=> (out_sin == -$past(s2_sin) && out_cos == -$past(s2_cos))); // R6
  AST_FOLD_Q3: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && s2_quad == 2'd3) |=> (out_sin == -$past(s2_cos) && out_cos == $past(s2_sin))); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_valid |=> ($stable(out_sin) && $stable(out_cos))); // R8
endmodule

bind quad_trig_lut trig_chk #(.AMP_W(AMP_W)) u_trig_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_sin(out_sin), .out_cos(out_cos), .s2_valid(s2_valid), .s2_quad(s2_quad),
  .s2_sin(s2_sin), .s2_cos(s2_cos));

// File: tb/test_quad_trig_lut.sv
`timescale 1ns/1ps
module test_quad_trig_lut;
  localparam int PW = 8;
  localparam int AW = 12;
  localparam int MAGV = (1 << (AW - 1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [PW-1:0] in_phase = '0;
  logic out_valid;
  logic signed [AW-1:0] out_sin, out_cos;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  quad_trig_lut #(.PHASE_W(PW), .AMP_W(AW)) i_quad_trig_lut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_phase(in_phase),
    .out_valid(out_valid), .out_sin(out_sin), .out_cos(out_cos));

  // reference: full-circle angle, first-quadrant samples, then quadrant rules
  function automatic void ref_pair(input int ph, output int es, output int ec);
    int q, k, s, c;
    real a;
    q = ph / (1 << (PW - 2));
    k = ph % (1 << (PW - 2));
    a = 2.0 * 3.141592653589793 * real'(k) / real'(1 << PW);
    s = $rtoi($sin(a) * real'(MAGV) + 0.5);
    c = $rtoi($cos(a) * real'(MAGV) + 0.5);
    if (q == 0)      begin es = s;  ec = c;  end
    else if (q == 1) begin es = c;  ec = -s; end
    else if (q == 2) begin es = -s; ec = -c; end
    else             begin es = -c; ec = s;  end
  endfunction

  // pipeline model: queues of three slots
  bit pv[3];
  int ps[3], pc[3], pq[3];
  int hold_s = 0, hold_c = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin pv[i] = 0; ps[i] = 0; pc[i] = 0; pq[i] = 0; end
    end else begin
      int es, ec;
      for (int i = 2; i > 0; i--) begin
        pv[i] = pv[i-1]; ps[i] = ps[i-1]; pc[i] = pc[i-1]; pq[i] = pq[i-1];
      end
      ref_pair(int'(in_phase), es, ec);
      pv[0] = in_valid; ps[0] = es; pc[0] = ec; pq[0] = int'(in_phase) >> (PW - 2);
      if (pv[2]) begin hold_s = ps[2]; hold_c = pc[2]; end
    end
  end

  function automatic string qtag(input int q);
    case (q)
      0: return "R2";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp++;
      if (out_valid !== pv[2]) begin
        n_bad++;
        $display("FAIL R3 out_valid actual %0b expected %0b", out_valid, pv[2]);
      end
      if (pv[2]) begin
        n_cmp++;
        if (int'(out_sin) != ps[2] || int'(out_cos) != pc[2]) begin
          n_bad++;
          $display("FAIL %s sin/cos actual %0d/%0d expected %0d/%0d",
                   qtag(pq[2]), out_sin, out_cos, ps[2], pc[2]);
        end
        n_cmp++;
        if (int'(out_sin) < -MAGV || int'(out_cos) < -MAGV) begin
          n_bad++;
          $display("FAIL R4 magnitude actual %0d/%0d expected within %0d",
                   out_sin, out_cos, MAGV);
        end
      end else begin
        n_cmp++;
        if (int'(out_sin) != hold_s || int'(out_cos) != hold_c) begin
          n_bad++;
          $display("FAIL R8 held sin/cos actual %0d/%0d expected %0d/%0d",
                   out_sin, out_cos, hold_s, hold_c);
        end
      end
    end
  end

  task automatic send(input bit v, input int ph);
    @(negedge clk);
    in_valid = v;
    in_phase = PW'(ph);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    n_cmp++;
    if (out_valid !== 1'b0 || out_sin !== '0 || out_cos !== '0) begin
      n_bad++;
      $display("FAIL R1 reset actual %0b %0d %0d expected 0 0 0", out_valid, out_sin, out_cos);
    end
    rst_n = 1'b1;
    // R4: phase 0 alone gives 0 / full scale
    send(1, 0);
    send(0, 0);
    repeat (3) @(negedge clk);
    n_cmp++;
    if (int'(out_sin) != 0 || int'(out_cos) != MAGV) begin
      n_bad++;
      $display("FAIL R4 phase0 actual %0d/%0d expected 0/%0d", out_sin, out_cos, MAGV);
    end
    // R2 R5 R6 R7 R3: full sweep back to back
    for (int p = 0; p < (1 << PW); p++) send(1, p);
    send(0, 0);
    repeat (4) @(negedge clk);
    // quadrant edges with gaps (R3, R8)
    begin
      int edges[8] = '{0, 63, 64, 127, 128, 191, 192, 255};
      foreach (edges[i]) begin
        send(1, edges[i]);
        for (int g = 0; g < (i % 3); g++) send(0, 255 - i);
      end
    end
    // descending burst with alternating gaps
    for (int p = 255; p >= 0; p -= 7) begin
      send(1, p);
      if (p % 2 == 0) send(0, p);
    end
    send(0, 0);
    repeat (6) @(negedge clk);
    finish_run();
  end
endmodule